// File: doc/BRIEF.md
# Register Window Address Translator

This block turns a 4-bit register number taken from an instruction into a 10-bit address in the internal data memory. Two small pieces of state control the mapping. A 6-bit window base is XORed into the address at bit 2 and above, so a program can move the active register window in steps of four words. A 3-bit map mode chooses which mix of the upper register-number bits drives address bit 8. Each is written by its own load strobe, and both take their value from a shared 10-bit operand bus.

The block offers two access paths. The lookup port is purely combinational: it takes a register number and returns the translated address straight away, using the registered base and mode. The request path is a valid/ready stream. An accepted request is translated with the state of its acceptance cycle. A direct request comes back on the output stream one cycle later. An indirect request first reads a memory word at the translated address over a plain read port, and the low ten bits of that word become the returned address. Only one request is in flight at a time, and `req_ready` stays low until the output beat has been taken. The output holds `out_valid` and `out_addr` steady for as long as `out_ready` stays low, so back-pressure never loses a result.

Top module: `regwin_xlate`

## Requirements
- R1: After reset the window base and the map mode are both zero, `req_ready` is 1, and `out_valid` and `mem_rd_en` are 0.
- R2: Address bits 2:0 come from register bits 2:0 and address bit 9 comes from register bit 3, in both cases before the base XOR. With a base of zero, address bits 7:3 are 0.
- R3: Address bit 8 is chosen by the map mode. Let x be register bit 2 and y be register bit 3. Modes 0 to 3 select x, mode 4 selects y, mode 5 selects NOT y, mode 6 selects x AND y, and mode 7 selects x OR y.
- R4: The translated address equals the unbased address XOR (base × 4), so the base changes address bits 7:2 only.
- R5: A pulse on `ld_base` loads `ld_arg[5:0]` into the base, and a pulse on `ld_map` loads `ld_arg[2:0]` into the mode. The higher operand bits are ignored. The new value is used from the clock edge that samples the strobe onward.
- R6: When `ld_base` and `ld_map` are pulsed in the same cycle, both are loaded, each from its own field of `ld_arg`.
- R7: A request accepted with `req_ind`=0 shows up on the output with `out_valid`=1 in the next cycle. Its `out_addr` is the translation of `req_reg`.
- R8: A request accepted with `req_ind`=1 raises `mem_rd_en` in the next cycle, with `mem_rd_addr` set to the translation. Both are held until `mem_rd_done` is sampled high. The cycle after that, `out_valid` is 1 and `out_addr` equals `mem_rd_data[9:0]`.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_addr` stay unchanged. `req_ready` is 0 from the acceptance of a request until its output beat has been taken.
- R10: A request accepted in the same cycle as a load strobe is translated with the base and mode that were in force before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_base | input | 1 | Load window base from `ld_arg[5:0]` |
| ld_map | input | 1 | Load map mode from `ld_arg[2:0]` |
| ld_arg | input | 10 | Operand field for both loads |
| lookup_reg | input | 4 | Register number for the combinational lookup |
| lookup_addr | output | 10 | Translated address of `lookup_reg` |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready (idle) |
| req_reg | input | 4 | Register number of the request |
| req_ind | input | 1 | Request takes the indirect path |
| mem_rd_en | output | 1 | Memory read request, held until done |
| mem_rd_addr | output | 10 | Memory read address |
| mem_rd_data | input | 16 | Word returned by memory |
| mem_rd_done | input | 1 | Read data valid this cycle |
| out_valid | output | 1 | Output stream valid |
| out_ready | input | 1 | Output stream ready |
| out_addr | output | 10 | Final effective address |

## Verification
The bench builds the block with its default parameters: a 4-bit register number, a 10-bit address, a 6-bit base, a 3-bit mode, a 16-bit memory word, and the indirect stage enabled. With these values the random load phase can reach all eight map modes and all 64 base values, and both the direct and the indirect stream paths are exercised. The memory model returns words whose upper six bits are not zero, so the bench can see the truncation to ten bits. The output-ready signal is driven low at random to exercise back-pressure.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_READ = 2'd1,
    WALK_SEND = 2'd2
  } walk_state_t;

  localparam int unsigned BASE_SHIFT = 2;

endpackage

// File: rtl/regwin_state.sv
module regwin_state #(
  parameter int unsigned ARG_W  = 10,
  parameter int unsigned BASE_W = 6,
  parameter int unsigned MAP_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_base,
  input  logic              ld_map,
  input  logic [ARG_W-1:0]  ld_arg,
  output logic [BASE_W-1:0] base_q,
  output logic [MAP_W-1:0]  map_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      map_q  <= '0;
    end else begin
      if (ld_base) base_q <= ld_arg[BASE_W-1:0];
      if (ld_map)  map_q  <= ld_arg[MAP_W-1:0];
    end
  end

  // R5 / R6: each strobe loads its own field
  p_base_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_base |=> base_q == $past(ld_arg[BASE_W-1:0]));
  p_map_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_map |=> map_q == $past(ld_arg[MAP_W-1:0]));
  p_base_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_base |=> $stable(base_q));
  p_map_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_map |=> $stable(map_q));

endmodule

// File: rtl/regwin_map.sv
module regwin_map
  import regwin_pkg::*;
#(
  parameter int unsigned REG_W  = 4,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned BASE_W = 6,
  parameter int unsigned MAP_W  = 3
) (
  input  logic [REG_W-1:0]  reg_num,
  input  logic [BASE_W-1:0] base,
  input  logic [MAP_W-1:0]  mode,
  output logic [ADDR_W-1:0] addr
);

  localparam int unsigned TOP_POS = ADDR_W - 1;
  localparam int unsigned SEL_POS = ADDR_W - 2;
  localparam int unsigned LOW_W   = REG_W - 1;

  logic              bit_x;
  logic              bit_y;
  logic              sel;
  logic [ADDR_W-1:0] plain;
  logic [ADDR_W-1:0] offset;

  assign bit_x = reg_num[REG_W-2];
  assign bit_y = reg_num[REG_W-1];

  always_comb begin
    unique case (mode)
      3'd4:    sel = bit_y;
      3'd5:    sel = ~bit_y;
      3'd6:    sel = bit_x & bit_y;
      3'd7:    sel = bit_x | bit_y;
      default: sel = bit_x;
    endcase
  end

  always_comb begin
    plain               = '0;
    plain[LOW_W-1:0]    = reg_num[LOW_W-1:0];
    plain[SEL_POS]      = sel;
    plain[TOP_POS]      = bit_y;
  end

  assign offset = ADDR_W'({base, {BASE_SHIFT{1'b0}}});
  assign addr   = plain ^ offset;

endmodule

// File: rtl/regwin_walk.sv
module regwin_walk
  import regwin_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_ind,
  input  logic [ADDR_W-1:0] xl_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              mem_rd_done,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr
);

  walk_state_t       st;
  logic [ADDR_W-1:0] hold;
  logic              unused_hi;

  assign unused_hi = ^mem_rd_data[DATA_W-1:ADDR_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= WALK_IDLE;
      hold <= '0;
    end else begin
      unique case (st)
        WALK_IDLE: if (req_valid) begin
          hold <= xl_addr;
          st   <= req_ind ? WALK_READ : WALK_SEND;
        end
        WALK_READ: if (mem_rd_done) begin
          hold <= mem_rd_data[ADDR_W-1:0];
          st   <= WALK_SEND;
        end
        WALK_SEND: if (out_ready) st <= WALK_IDLE;
        default: st <= WALK_IDLE;
      endcase
    end
  end

  assign req_ready   = (st == WALK_IDLE);
  assign mem_rd_en   = (st == WALK_READ);
  assign out_valid   = (st == WALK_SEND);
  assign mem_rd_addr = hold;
  assign out_addr    = hold;

  p_direct_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_ind |=> out_valid && out_addr == $past(xl_addr));
  p_ind_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_ind |=> mem_rd_en && mem_rd_addr == $past(xl_addr));
  p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && !mem_rd_done |=> mem_rd_en && $stable(mem_rd_addr));
  p_rd_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en && mem_rd_done |=> out_valid && out_addr == $past(mem_rd_data[ADDR_W-1:0]));
  p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr));
  p_one_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, mem_rd_en, out_valid}));

endmodule

// File: rtl/regwin_xlate.sv
module regwin_xlate
  import regwin_pkg::*;
#(
  parameter int unsigned REG_W  = 4,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned ARG_W  = 10,
  parameter int unsigned BASE_W = 6,
  parameter int unsigned MAP_W  = 3,
  parameter int unsigned DATA_W = 16,
  parameter bit          IND_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_base,
  input  logic              ld_map,
  input  logic [ARG_W-1:0]  ld_arg,
  input  logic [REG_W-1:0]  lookup_reg,
  output logic [ADDR_W-1:0] lookup_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [REG_W-1:0]  req_reg,
  input  logic              req_ind,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  input  logic              mem_rd_done,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr
);

  logic [BASE_W-1:0] base_q;
  logic [MAP_W-1:0]  map_q;
  logic [ADDR_W-1:0] req_xl;
  logic              use_ind;

  regwin_state #(.ARG_W(ARG_W), .BASE_W(BASE_W), .MAP_W(MAP_W)) u_state (
    .clk(clk), .rst_n(rst_n), .ld_base(ld_base), .ld_map(ld_map),
    .ld_arg(ld_arg), .base_q(base_q), .map_q(map_q)
  );

  regwin_map #(.REG_W(REG_W), .ADDR_W(ADDR_W), .BASE_W(BASE_W), .MAP_W(MAP_W)) u_map_look (
    .reg_num(lookup_reg), .base(base_q), .mode(map_q), .addr(lookup_addr)
  );

  regwin_map #(.REG_W(REG_W), .ADDR_W(ADDR_W), .BASE_W(BASE_W), .MAP_W(MAP_W)) u_map_req (
    .reg_num(req_reg), .base(base_q), .mode(map_q), .addr(req_xl)
  );

  generate
    if (IND_EN) begin : g_ind
      assign use_ind = req_ind;
    end else begin : g_direct
      logic unused_ind;
      assign unused_ind = req_ind;
      assign use_ind    = 1'b0;
    end
  endgenerate

  regwin_walk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_ind(use_ind), .xl_addr(req_xl), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_rd_done(mem_rd_done), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr)
  );

  p_top_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_addr[ADDR_W-1] == lookup_reg[REG_W-1]);
  p_low_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_addr[1:0] == lookup_reg[1:0]);

endmodule

// File: tb/regwin_xlate_test.sv
module regwin_xlate_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_base = 1'b0, ld_map = 1'b0;
  logic [9:0] ld_arg = '0;
  logic [3:0] lookup_reg = '0;
  logic [9:0] lookup_addr;
  logic       req_valid = 1'b0, req_ready, req_ind = 1'b0;
  logic [3:0] req_reg = '0;
  logic       mem_rd_en, mem_rd_done = 1'b0;
  logic [9:0] mem_rd_addr;
  logic [15:0] mem_rd_data = '0;
  logic       out_valid, out_ready = 1'b0;
  logic [9:0] out_addr;

  int total = 0, bad = 0, cyc = 0;
  bit live = 0;

  always #4 clk = ~clk;

  regwin_xlate uut (
    .clk(clk), .rst_n(rst_n), .ld_base(ld_base), .ld_map(ld_map), .ld_arg(ld_arg),
    .lookup_reg(lookup_reg), .lookup_addr(lookup_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_reg(req_reg), .req_ind(req_ind),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_rd_done(mem_rd_done), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr)
  );

  function automatic logic [15:0] memw(input int a);
    return 16'((a * 37 + 11) ^ 16'hB6C0);
  endfunction

  function automatic logic [9:0] ref_xl(input int r, input int b, input int m);
    int x, y, s;
    x = (r >> 2) & 1;
    y = (r >> 3) & 1;
    case (m)
      4: s = y;
      5: s = 1 - y;
      6: s = x & y;
      7: s = x | y;
      default: s = x;
    endcase
    return 10'(((r & 7) | (s << 8) | (y << 9)) ^ (b * 4));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // memory model: answers one cycle after the read is seen
  always @(posedge clk) begin
    mem_rd_done <= mem_rd_en && !mem_rd_done;
    mem_rd_data <= memw(int'(mem_rd_addr));
  end

  // reference model
  int base_m = 0, map_m = 0, ph = 0;
  int exp_rd = 0, exp_out = 0;
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      base_m = 0; map_m = 0; ph = 0;
    end else begin
      int nb, nm;
      nb = ld_base ? int'(ld_arg) & 63 : base_m;
      nm = ld_map  ? int'(ld_arg) & 7  : map_m;
      case (ph)
        0: if (req_valid) begin
          if (req_ind) begin exp_rd = ref_xl(req_reg, base_m, map_m); ph = 1; end
          else begin exp_out = ref_xl(req_reg, base_m, map_m); ph = 2; end
        end
        1: if (mem_rd_done) begin exp_out = int'(memw(exp_rd)) & 10'h3FF; ph = 2; end
        default: if (out_ready) ph = 0;
      endcase
      base_m = nb; map_m = nm;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (live) begin
      chk("R2 R3 R4 lookup", lookup_addr, ref_xl(lookup_reg, base_m, map_m));
      chk("R9 req_ready", req_ready, ph == 0);
      chk("R8 mem_rd_en", mem_rd_en, ph == 1);
      chk("R7 out_valid", out_valid, ph == 2);
      if (ph == 1) chk("R8 mem_rd_addr", mem_rd_addr, exp_rd);
      if (ph == 2) chk("R7 R8 R10 out_addr", out_addr, exp_out);
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic load(input bit b, input bit m, input int arg);
    ld_base = b; ld_map = m; ld_arg = 10'(arg);
    step();
    ld_base = 0; ld_map = 0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    lookup_reg = 4'hC;
    #1;
    chk("R1 lookup after reset", lookup_addr, 10'h304);
    chk("R1 req_ready", req_ready, 1);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 mem_rd_en", mem_rd_en, 0);
    live = 1;

    // R5 / R6: upper operand bits ignored, both loaded together
    load(1, 1, 10'h3FF);
    lookup_reg = 4'h0; #1;
    chk("R5 R6 base 63 mode 7 reg 0", lookup_addr, 10'h0FC);
    lookup_reg = 4'hC; #1;
    chk("R5 R6 base 63 mode 7 reg C", lookup_addr, 10'h3F8);

    // R3 map modes with base 0
    load(1, 1, 10'h005);
    load(1, 0, 10'h000);
    lookup_reg = 4'h0; #1; chk("R3 mode 5 reg 0", lookup_addr, 10'h100);
    lookup_reg = 4'h8; #1; chk("R3 mode 5 reg 8", lookup_addr, 10'h200);
    load(0, 1, 10'h3C6);
    lookup_reg = 4'h4; #1; chk("R3 mode 6 reg 4", lookup_addr, 10'h004);
    lookup_reg = 4'hF; #1; chk("R3 mode 6 reg F", lookup_addr, 10'h307);
    load(0, 1, 10'h004);
    lookup_reg = 4'h8; #1; chk("R3 mode 4 reg 8", lookup_addr, 10'h300);
    load(0, 1, 10'h002);
    lookup_reg = 4'h4; #1; chk("R3 mode 2 reg 4", lookup_addr, 10'h104);
    load(0, 1, 10'h000);

    // R10 + R7: request with same-cycle base load uses old base
    req_valid = 1; req_reg = 4'h1; req_ind = 0;
    ld_base = 1; ld_arg = 10'h001;
    step();
    req_valid = 0; ld_base = 0;
    chk("R7 out_valid next cycle", out_valid, 1);
    chk("R10 old base used", out_addr, 10'h001);
    // R9: hold under back-pressure
    step(); step();
    chk("R9 out_valid held", out_valid, 1);
    chk("R9 out_addr held", out_addr, 10'h001);
    chk("R9 req_ready low", req_ready, 0);
    out_ready = 1; step(); out_ready = 0;
    load(1, 0, 10'h000);

    // R8: indirect read
    req_valid = 1; req_reg = 4'h3; req_ind = 1;
    step();
    req_valid = 0; req_ind = 0;
    chk("R8 read issued", mem_rd_en, 1);
    chk("R8 read address", mem_rd_addr, 10'h003);
    step();
    chk("R8 read held", mem_rd_en, 1);
    step();
    chk("R8 indirect result valid", out_valid, 1);
    chk("R8 indirect result", out_addr, int'(memw(3)) & 10'h3FF);
    out_ready = 1; step();

    // random mixed traffic
    for (int i = 0; i < 600; i++) begin
      ld_base    = ($urandom % 8) == 0;
      ld_map     = ($urandom % 8) == 0;
      ld_arg     = 10'($urandom);
      lookup_reg = 4'($urandom);
      req_valid  = ($urandom % 3) != 0;
      req_reg    = 4'($urandom);
      req_ind    = ($urandom % 2) == 0;
      out_ready  = ($urandom % 4) != 0;
      step();
    end
    ld_base = 0; ld_map = 0; req_valid = 0; out_ready = 1;
    repeat (4) step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule